// File: doc/BRIEF.md
# Software Interrupt Fan-Out with Multi-CPU Completion

This block raises software interrupts in a system of two processors. A single register write names one of sixteen interrupt numbers and a set of destination processors. For each named processor the block sets its own pending flag for that number, so the state is a matrix of sixteen rows (interrupt numbers) by two columns (processors). A write creates one event. It does not hold a level, so writing the same number again while it is still outstanding adds nothing.

Each processor reports that it has handled an interrupt by giving an acknowledge strobe together with the interrupt number. That strobe clears only the flag in its own column of that row. An interrupt counts as finished only when every processor that was sent it has acknowledged it. A one-cycle completion pulse for that number marks the moment its row becomes empty.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every pending flag is 0 and every completion pulse output is 0.
- R2: A write with `wr_en`=1 takes the interrupt number from `wr_data[3:0]` and the destination mask from `wr_data[17:16]` (bit 16 is CPU 0, bit 17 is CPU 1). One cycle later the flag [number][n] is set for each mask bit n that is 1. All other bits of `wr_data` have no effect.
- R3: No flag is set in a cycle that has `wr_en`=0, and none is set by a write whose mask is 0.
- R4: An acknowledge from CPU n (`ack_valid[n]`=1, number in `ack_id[4n+3:4n]`) clears flag [number][n] one cycle later. It leaves every other flag unchanged, including the same number's flag for the other CPU.
- R5: An acknowledge of a flag that is not set changes nothing.
- R6: A write to a flag that is already set leaves it set and is not counted as a second event: a single acknowledge then clears it.
- R7: When a write and an acknowledge hit the same flag in the same cycle, the flag is 1 afterwards.
- R8: `done[k]` is 1 for exactly one cycle. That cycle is the first cycle in which row k reads all zero after a cycle in which it was non-zero.
- R9: No completion pulse is raised while another destination CPU still holds the number. None is raised when a write sets a flag of that row in the same cycle as its last flag is acknowledged.
- R10: The pending output carries flag [k][n] at bit `pend[16*n + k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Generate-register write strobe |
| wr_data | input | 32 | Write payload: number in [3:0], CPU mask in [17:16] |
| ack_valid | input | 2 | Per-CPU acknowledge strobe |
| ack_id | input | 8 | Per-CPU acknowledged number, CPU n at [4n+3:4n] |
| pend | output | 32 | Pending matrix, flag [k][n] at bit 16n+k |
| done | output | 16 | One-cycle completion pulse per interrupt number |

## Verification
Directed cases cover the following:
- a write with junk in the unused payload bits;
- a zero-mask write;
- a repeat write to a flag already set;
- acknowledges in both orders for a two-CPU interrupt;
- an acknowledge of a flag that is not set;
- a write and an acknowledge on the same flag in one cycle;
- a re-arm in the same cycle as the last acknowledge.

Together these separate the per-column clear from a whole-row clear, and the set-wins rule from the clear-wins rule. They also show whether the completion pulse waits for every destination. A long random phase with a narrow number range then makes collisions frequent, so writes and acknowledges often land on the same row in the same cycle. A bench model compares the full matrix and the pulse vector every cycle.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NUM_ID   = 16,
  parameter int NUM_CPU  = 2,
  parameter int ID_W     = $clog2(NUM_ID),
  parameter int MASK_LSB = 16,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [NUM_CPU-1:0]        ack_valid,
  input  logic [NUM_CPU*ID_W-1:0]   ack_id,
  output logic [NUM_CPU*NUM_ID-1:0] pend,
  output logic [NUM_ID-1:0]         done
);
  localparam int CELLS = NUM_CPU * NUM_ID;

  wire [ID_W-1:0]    wr_id   = wr_data[ID_W-1:0];
  wire [NUM_CPU-1:0] wr_mask = wr_data[MASK_LSB +: NUM_CPU];

  logic [CELLS-1:0]  pend_q, pend_d;
  logic [NUM_ID-1:0] row_now, row_next, done_q;

  for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
    for (genvar k = 0; k < NUM_ID; k++) begin : g_id
      wire hit_set = wr_en && wr_mask[n] && (wr_id == ID_W'(k));
      wire hit_clr = ack_valid[n] && (ack_id[n*ID_W +: ID_W] == ID_W'(k));
      assign pend_d[n*NUM_ID+k] = (pend_q[n*NUM_ID+k] && !hit_clr) || hit_set;
    end
  end

  always_comb begin
    row_now  = '0;
    row_next = '0;
    for (int n = 0; n < NUM_CPU; n++) begin
      row_now  = row_now  | pend_q[n*NUM_ID +: NUM_ID];
      row_next = row_next | pend_d[n*NUM_ID +: NUM_ID];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= '0;
    end else begin
      pend_q <= pend_d;
      done_q <= row_now & ~row_next;
    end
  end

  assign pend = pend_q;
  assign done = done_q;
endmodule

module sgi_dispatch_chk #(
  parameter int NUM_ID   = 16,
  parameter int NUM_CPU  = 2,
  parameter int ID_W     = $clog2(NUM_ID),
  parameter int MASK_LSB = 16,
  parameter int DATA_W   = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [DATA_W-1:0]         wr_data,
  input logic [NUM_CPU-1:0]        ack_valid,
  input logic [NUM_CPU*ID_W-1:0]   ack_id,
  input logic [NUM_CPU*NUM_ID-1:0] pend,
  input logic [NUM_ID-1:0]         done
);
  logic [NUM_ID-1:0] row_busy;
  always_comb begin
    row_busy = '0;
    for (int n = 0; n < NUM_CPU; n++) row_busy = row_busy | pend[n*NUM_ID +: NUM_ID];
  end

  p_quiet_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((pend & ~$past(pend)) == '0));

  for (genvar n = 0; n < NUM_CPU; n++) begin : g_c
    p_write_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[MASK_LSB+n]) |=> pend[n*NUM_ID + int'($past(wr_data[ID_W-1:0]))]);

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid[n] && !(wr_en && wr_data[MASK_LSB+n] &&
        wr_data[ID_W-1:0] == ack_id[n*ID_W +: ID_W]))
      |=> !pend[n*NUM_ID + int'($past(ack_id[n*ID_W +: ID_W]))]);
  end

  for (genvar k = 0; k < NUM_ID; k++) begin : g_k
    p_done_row_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done[k] |-> !row_busy[k]);
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done[k] |-> $past(row_busy[k]));
  end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(
  .NUM_ID(NUM_ID), .NUM_CPU(NUM_CPU), .ID_W(ID_W), .MASK_LSB(MASK_LSB), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ack_valid(ack_valid), .ack_id(ack_id), .pend(pend), .done(done)
);

// File: tb/tb_sgi_dispatch.sv
module tb_sgi_dispatch;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [1:0]  ack_valid = '0;
  logic [7:0]  ack_id = '0;
  logic [31:0] pend;
  logic [15:0] done;

  logic [31:0] m_pend = '0;
  logic [15:0] m_done = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sgi_dispatch dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                    .ack_valid(ack_valid), .ack_id(ack_id), .pend(pend), .done(done));

  function automatic logic [31:0] next_pend(logic [31:0] p, logic we, logic [31:0] d,
                                            logic [1:0] av, logic [7:0] aid);
    logic [31:0] r = p;
    for (int n = 0; n < 2; n++) begin
      if (av[n]) r[n*16 + aid[n*4 +: 4]] = 1'b0;
    end
    for (int n = 0; n < 2; n++) begin
      if (we && d[16+n]) r[n*16 + d[3:0]] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [15:0] rows(logic [31:0] p);
    return p[15:0] | p[31:16];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic we, logic [31:0] d, logic [1:0] av, logic [7:0] aid);
    logic [31:0] nx;
    @(negedge clk);
    wr_en = we; wr_data = d; ack_valid = av; ack_id = aid;
    nx = next_pend(m_pend, we, d, av, aid);
    m_done = rows(m_pend) & ~rows(nx);
    m_pend = nx;
    @(posedge clk); #1;
    check({tag, " pend"}, pend, m_pend);
    check({tag, " done"}, {16'h0, done}, {16'h0, m_done});
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 32'h0, 2'b00, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pend", pend, 32'h0);
    check("R1 reset done", {16'h0, done}, 32'h0);
    @(negedge clk); rst_n = 1;

    step("R2 write id5 cpu0 junk bits", 1'b1, 32'hF0E1_3A55 & ~32'h0002_0000 | 32'h0001_0000, 2'b00, 8'h0);
    check("R10 bit 5 is [5][0]", {31'h0, pend[5]}, 32'h1);
    check("R10 bit 21 clear", {31'h0, pend[21]}, 32'h0);
    step("R3 zero mask", 1'b1, 32'h0000_0007, 2'b00, 8'h0);
    step("R3 no write", 1'b0, 32'h0003_0009, 2'b00, 8'h0);
    step("R6 rewrite id5 both", 1'b1, 32'h0003_0005, 2'b00, 8'h0);
    check("R10 bit 21 is [5][1]", {31'h0, pend[21]}, 32'h1);
    step("R6 R4 ack cpu0 id5", 1'b0, 32'h0, 2'b01, 8'h05);
    check("R9 no done cpu1 pending", {16'h0, done}, 32'h0);
    step("R8 ack cpu1 id5", 1'b0, 32'h0, 2'b10, 8'h50);
    check("R8 done5 pulse", {16'h0, done}, 32'h0000_0020);
    idle("R8 pulse one cycle");
    check("R8 done low after", {16'h0, done}, 32'h0);
    step("R5 ack not pending", 1'b0, 32'h0, 2'b01, 8'h09);
    step("R7 write+ack same", 1'b1, 32'h0001_0003, 2'b01, 8'h03);
    check("R7 entry stays", {31'h0, pend[3]}, 32'h1);
    step("R7 ack alone", 1'b0, 32'h0, 2'b01, 8'h03);
    check("R8 done3", {16'h0, done}, 32'h0000_0008);
    step("R9 arm [4][1]", 1'b1, 32'h0002_0004, 2'b00, 8'h0);
    step("R9 rearm with last ack", 1'b1, 32'h0001_0004, 2'b10, 8'h40);
    check("R9 no done on rearm", {16'h0, done}, 32'h0);
    step("R4 arm two", 1'b1, 32'h0003_0002, 2'b00, 8'h0);
    step("R4 two acks differ", 1'b0, 32'h0, 2'b11, 8'h24);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic [7:0] a;
      d = $urandom;
      d[3:0] = 4'($urandom_range(0, 5));
      a = {4'($urandom_range(0, 5)), 4'($urandom_range(0, 5))};
      step("R2 R4 R8 random", ($urandom_range(0, 2) == 0), d, 2'($urandom), a);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule